// File: doc/BRIEF.md
# SD/MMC Command Line Engine

This block drives the single-wire command line of a memory-card host. Software first writes a 32-bit argument and then a command word. The engine serialises a 48-bit frame onto the line. The frame is a start bit, a direction bit, the 6-bit index, the argument, a CRC7 and an end bit. Depending on the command word, the engine then listens for no reply, a 48-bit reply or a 136-bit reply. Any reply is captured into a bank of four 32-bit words, its checksum is verified, and one of four sticky status flags is raised.

All line activity advances on a one-cycle `tick` strobe that marks each card-clock period. The system clock can therefore run faster than the card clock. Writing a command word whose enable bit is clear stops the engine at once, whatever it is doing.

Top module: `cmd_path_engine`

## Requirements
- R1: After a command word write with bit 8 set, each of the next 48 ticks presents one frame bit on `cmd_out` with `cmd_oe` high. The bits go out in this order: 0, 1, index bits 5..0, argument bits 31..0, CRC7 bits 6..0, and then 1. `cmd_oe` is low one tick after the end bit and stays low while a reply is received.
- R2: The frame CRC7 uses generator x^7+x^3+1 with a zero start value, computed over the first 40 frame bits, most significant bit first.
- R3: With bit 6 (reply expected) clear, the tick that sends the end bit sets status bit 0 (sent) and drops `busy`. At most one status bit is set at any time.
- R4: A short reply (bit 6 set, bit 7 clear) is 48 bits. Its bits 8..39 go to word 0, which is `resp_o[127:96]`. Words 1..3 keep their old values. A good CRC over reply bits 0..39 sets status bit 1.
- R5: A long reply (bits 6 and 7 set) is 136 bits. Reply bits 8..135 fill `resp_o[127:0]` most significant bit first. The CRC covers only reply bits 8..127; the checksum sits in bits 128..134.
- R6: A reply whose CRC does not match sets status bit 2 instead of bit 1. The words are loaded in either case.
- R7: If the line is sampled high on 64 consecutive ticks after the end bit, status bit 3 (timeout) is set and `busy` drops. A start bit seen on the 64th sample is accepted.
- R8: A command word write with bit 8 clear (zero included) returns the engine to idle at once. `cmd_oe` goes low, no status bit is set, and later line activity changes nothing.
- R9: When an abort write falls on the same cycle as the tick of a reply's final bit, the abort wins. No flag is set and the reply words are not updated.
- R10: Reset gives `busy`=0, `cmd_oe`=0, `cmd_out`=1, `status`=0 and `resp_o`=0. Every command word write clears `status`.
- R11: Without `tick`, no line state advances. `cmd_out`, `cmd_oe` and `busy` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe per card-clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the argument, 1 selects the command word |
| wr_data | input | 32 | Write data; command word: [5:0] index, [6] reply expected, [7] long reply, [8] enable |
| cmd_in | input | 1 | Command line as seen from the card |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| busy | output | 1 | Engine is not idle |
| status | output | 4 | Sticky flags: [0] sent, [1] reply ok, [2] reply CRC fail, [3] timeout |
| resp_o | output | 128 | Reply words, word 0 at [127:96] |

## Verification
Two events can share a cycle here: a software abort and the tick that carries a reply's last bit. The bench provokes this by holding back the final reply bit and then issuing the abort write and that tick together. The result is judged by the absence of any flag and by reply words that still hold the previous command's value. A second coincidence, the start bit arriving on the very sample that would expire the timeout, is also driven and must end in an accepted reply.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_RECV = 2'd3
  } cmdp_state_e;

  localparam int CRC_W    = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

  localparam int FLG_SENT = 0;
  localparam int FLG_OK   = 1;
  localparam int FLG_CRC  = 2;
  localparam int FLG_TO   = 3;
  localparam int FLG_N    = 4;
endpackage

// File: rtl/cmdp_crc7.sv
module cmdp_crc7
  import cmdp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  logic fb;
  assign fb = din ^ crc[CRC_W-1];

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (en)    crc <= {crc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end
endmodule

// File: rtl/cmdp_rx_shift.sv
module cmdp_rx_shift #(
  parameter int SH_W = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            din,
  output logic [SH_W-1:0] sh
);
  always_ff @(posedge clk) begin
    if (rst)     sh <= '0;
    else if (en) sh <= {sh[SH_W-2:0], din};
  end
endmodule

// File: rtl/cmdp_resp_bank.sv
module cmdp_resp_bank #(
  parameter int RESP_W = 32,
  parameter int NRESP  = 4,
  parameter int HDR_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_long,
  input  logic                    ld_short,
  input  logic [NRESP*RESP_W-1:0] sh_next,
  output logic [NRESP*RESP_W-1:0] resp_o
);
  for (genvar i = 0; i < NRESP; i++) begin : g_word
    logic [RESP_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else if (ld_long) begin
        word_q <= sh_next[(NRESP-i)*RESP_W-1 -: RESP_W];
      end else if (ld_short && (i == 0)) begin
        word_q <= sh_next[HDR_W+RESP_W-1 : HDR_W];
      end
    end
    assign resp_o[(NRESP-i)*RESP_W-1 -: RESP_W] = word_q;
  end
endmodule

// File: rtl/cmd_path_engine.sv
module cmd_path_engine
  import cmdp_pkg::*;
#(
  parameter int RESP_W   = 32,
  parameter int NRESP    = 4,
  parameter int IDX_W    = 6,
  parameter int TO_TICKS = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    wr_en,
  input  logic                    wr_addr,
  input  logic [RESP_W-1:0]       wr_data,
  input  logic                    cmd_in,
  output logic                    cmd_out,
  output logic                    cmd_oe,
  output logic                    busy,
  output logic [FLG_N-1:0]        status,
  output logic [NRESP*RESP_W-1:0] resp_o
);
  localparam int HDR_W = 2 + IDX_W;
  localparam int TXB   = HDR_W + RESP_W;
  localparam int FRM   = TXB + CRC_W + 1;
  localparam int LLEN  = HDR_W + NRESP * RESP_W;
  localparam int SH_W  = NRESP * RESP_W;
  localparam int CW    = $clog2(LLEN + 1);
  localparam int TW    = $clog2(TO_TICKS + 1);
  localparam int RSP_B = IDX_W;
  localparam int LNG_B = IDX_W + 1;
  localparam int EN_B  = IDX_W + 2;

  cmdp_state_e       state;
  logic [CW-1:0]     cnt;
  logic [TW-1:0]     timer;
  logic [RESP_W-1:0] arg_q;
  logic [TXB-1:0]    txsh;
  logic              rsp_q, long_q;
  logic [FLG_N-1:0]  status_q;
  logic              out_q, oe_q;
  logic [CRC_W-1:0]  crc_tx, crc_rx;
  logic [SH_W-1:0]   sh, sh_next;

  logic wr_cmd, wr_arg, step;
  assign wr_cmd = wr_en && wr_addr;
  assign wr_arg = wr_en && !wr_addr;
  assign step   = tick && !wr_cmd;

  logic [CW-1:0] rlen, rlo;
  assign rlen = long_q ? CW'(LLEN) : CW'(FRM);
  assign rlo  = long_q ? CW'(HDR_W) : '0;

  logic [2:0] ci;
  logic       tx_bit;
  always_comb begin
    ci = 3'(CW'(FRM - 2) - cnt);
    if (cnt < CW'(TXB))           tx_bit = txsh[TXB-1];
    else if (cnt < CW'(FRM - 1))  tx_bit = crc_tx[ci];
    else                          tx_bit = 1'b1;
  end

  logic start_seen, in_win, last_bit;
  assign start_seen = (state == ST_WAIT) && !cmd_in;
  assign in_win     = (cnt >= rlo) && (cnt <= rlen - CW'(2));
  assign last_bit   = step && (state == ST_RECV) && (cnt == rlen - CW'(1));
  assign sh_next    = {sh[SH_W-2:0], cmd_in};

  cmdp_crc7 u_crc_tx (
    .clk (clk), .rst (rst), .clr (wr_cmd),
    .en  (step && (state == ST_SEND) && (cnt < CW'(TXB))),
    .din (txsh[TXB-1]), .crc (crc_tx)
  );

  cmdp_crc7 u_crc_rx (
    .clk (clk), .rst (rst), .clr (wr_cmd),
    .en  (step && ((start_seen && !long_q) || ((state == ST_RECV) && in_win))),
    .din (cmd_in), .crc (crc_rx)
  );

  cmdp_rx_shift #(.SH_W(SH_W)) u_shift (
    .clk (clk), .rst (rst),
    .en  (step && (start_seen || (state == ST_RECV))),
    .din (cmd_in), .sh (sh)
  );

  cmdp_resp_bank #(.RESP_W(RESP_W), .NRESP(NRESP), .HDR_W(HDR_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .ld_long  (last_bit && long_q),
    .ld_short (last_bit && !long_q),
    .sh_next  (sh_next),
    .resp_o   (resp_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      timer    <= '0;
      arg_q    <= '0;
      txsh     <= '0;
      rsp_q    <= 1'b0;
      long_q   <= 1'b0;
      status_q <= '0;
      out_q    <= 1'b1;
      oe_q     <= 1'b0;
    end else begin
      if (wr_arg) arg_q <= wr_data;
      if (wr_cmd) begin
        status_q <= '0;
        if (wr_data[EN_B]) begin
          state  <= ST_SEND;
          cnt    <= '0;
          timer  <= '0;
          txsh   <= {2'b01, wr_data[IDX_W-1:0], arg_q};
          rsp_q  <= wr_data[RSP_B];
          long_q <= wr_data[LNG_B];
        end else begin
          state <= ST_IDLE;
          oe_q  <= 1'b0;
          out_q <= 1'b1;
        end
      end else if (tick) begin
        unique case (state)
          ST_SEND: begin
            out_q <= tx_bit;
            oe_q  <= 1'b1;
            if (cnt < CW'(TXB)) txsh <= txsh << 1;
            if (cnt == CW'(FRM - 1)) begin
              timer <= '0;
              if (rsp_q) begin
                state <= ST_WAIT;
              end else begin
                state              <= ST_IDLE;
                status_q[FLG_SENT] <= 1'b1;
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_WAIT: begin
            oe_q  <= 1'b0;
            out_q <= 1'b1;
            if (!cmd_in) begin
              state <= ST_RECV;
              cnt   <= CW'(1);
            end else if (timer == TW'(TO_TICKS - 1)) begin
              state            <= ST_IDLE;
              status_q[FLG_TO] <= 1'b1;
            end else begin
              timer <= timer + TW'(1);
            end
          end
          ST_RECV: begin
            oe_q <= 1'b0;
            if (cnt == rlen - CW'(1)) begin
              state <= ST_IDLE;
              if (crc_rx == '0) status_q[FLG_OK]  <= 1'b1;
              else              status_q[FLG_CRC] <= 1'b1;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          default: begin
            oe_q  <= 1'b0;
            out_q <= 1'b1;
          end
        endcase
      end
    end
  end

  assign cmd_out = out_q;
  assign cmd_oe  = oe_q;
  assign busy    = (state != ST_IDLE);
  assign status  = status_q;

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    $onehot0(status)); // R3
  AST_NO_DRIVE_RX: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RECV) |-> !cmd_oe); // R1
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> (timer < TW'(TO_TICKS))); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && !wr_data[EN_B]) |=> (!busy && !cmd_oe && (status == '0))); // R8
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wr_cmd |=> (status == '0)); // R10
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_cmd) |=> ($stable(state) && $stable(cnt) && $stable(cmd_out) && $stable(cmd_oe))); // R11
endmodule

// File: tb/test_cmd_path_engine.sv
module test_cmd_path_engine;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0;
  logic         wr_en = 1'b0;
  logic         wr_addr = 1'b0;
  logic [31:0]  wr_data = '0;
  logic         cmd_in = 1'b1;
  logic         cmd_out, cmd_oe, busy;
  logic [3:0]   status;
  logic [127:0] resp_o;

  always #5 clk = ~clk;

  cmd_path_engine i_cmd_path_engine (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .busy(busy), .status(status), .resp_o(resp_o)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  int  div = 1;
  bit  exp_busy = 1'b0;
  bit  mon_on = 1'b0;
  bit  done = 1'b0;

  // model of the busy output, compared on every clock (R1, R3, R8)
  always @(negedge clk) begin
    if (mon_on) begin
      n_chk++;
      if (busy !== exp_busy) begin
        n_fail++;
        $display("FAIL R8 busy monitor act=%0b exp=%0b at %0t", busy, exp_busy, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7f(input logic [119:0] v, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] mk_cmd(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h = {2'b01, idx, arg};
    return {h, crc7f({80'b0, h}, 40), 1'b1};
  endfunction

  function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] st);
    logic [39:0] h = {2'b00, idx, st};
    return {88'b0, h, crc7f({80'b0, h}, 40), 1'b1};
  endfunction

  function automatic logic [135:0] mk_long(input logic [119:0] p);
    return {2'b00, 6'h3F, p, crc7f(p, 120), 1'b1};
  endfunction

  function automatic logic [31:0] cw(input logic [5:0] idx, input bit r, input bit l);
    return {23'b0, 1'b1, l, r, idx};
  endfunction

  task automatic wr(input bit a, input logic [31:0] d, input bit t, input bit din);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick = t; cmd_in = din;
    @(posedge clk); #1;
    wr_en = 1'b0; tick = 1'b0; cmd_in = 1'b1;
    if (a) exp_busy = d[8];
  endtask

  task automatic tk(input bit din);
    repeat (div - 1) begin @(negedge clk); tick = 1'b0; end
    @(negedge clk);
    tick = 1'b1; cmd_in = din;
    @(posedge clk); #1;
    tick = 1'b0; cmd_in = 1'b1;
  endtask

  task automatic start_cmd(input logic [5:0] idx, input logic [31:0] arg, input bit r, input bit l);
    wr(1'b0, arg, 1'b0, 1'b1);
    wr(1'b1, cw(idx, r, l), 1'b0, 1'b1);
  endtask

  task automatic tx_frame(input logic [5:0] idx, input logic [31:0] arg, input bit r);
    logic [47:0] f = mk_cmd(idx, arg);
    for (int k = 0; k < 48; k++) begin
      tk(1'b1);
      if (k == 47 && !r) exp_busy = 1'b0;
      chk((k >= 40 && k < 47) ? "R2 crc bit" : "R1 frame bit", {cmd_oe, cmd_out}, {1'b1, f[47-k]});
    end
  endtask

  task automatic rx_reply(input logic [135:0] v, input int len, input int dly);
    repeat (dly) tk(1'b1);
    for (int k = 0; k < len; k++) begin
      tk(v[len-1-k]);
      if (k == len - 1) exp_busy = 1'b0;
      if (k == 20) chk("R1 oe low in reply", cmd_oe, 0);
    end
  endtask

  initial begin
    logic [135:0] v;
    logic [127:0] keep;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    mon_on = 1'b1;
    #1;
    // R10 reset state
    chk("R10 reset busy", busy, 0);
    chk("R10 reset oe/out", {cmd_oe, cmd_out}, 2'b01);
    chk("R10 reset status", status, 0);
    chk("R10 reset resp", resp_o, 0);

    // R3 no reply, full frame check at one tick per cycle
    div = 1;
    start_cmd(6'd0, 32'h0, 1'b0, 1'b0);
    tx_frame(6'd0, 32'h0, 1'b0);
    chk("R3 sent flag", status, 4'b0001);
    tk(1'b1);
    chk("R1 oe falls after end bit", cmd_oe, 0);

    // R10 flags cleared by write, then R4 short reply at divided tick
    div = 3;
    start_cmd(6'd17, 32'h12345678, 1'b1, 1'b0);
    chk("R10 write clears status", status, 0);
    tx_frame(6'd17, 32'h12345678, 1'b1);
    rx_reply(mk_short(6'd17, 32'hCAFEF00D), 48, 5);
    chk("R4 short ok flag", status, 4'b0010);
    chk("R4 word0", resp_o[127:96], 32'hCAFEF00D);
    chk("R4 words1-3 kept", resp_o[95:0], 0);

    // R5 long reply, start bit on the first sample
    div = 2;
    v = mk_long(120'h0123456789ABCDEF_FEDCBA98_7654321);
    start_cmd(6'd2, 32'hFFFF0000, 1'b1, 1'b1);
    tx_frame(6'd2, 32'hFFFF0000, 1'b1);
    rx_reply(v, 136, 0);
    chk("R5 long ok flag", status, 4'b0010);
    chk("R5 long words", resp_o, v[127:0]);

    // R6 short reply with damaged CRC
    div = 1;
    keep = resp_o;
    v = mk_short(6'd13, 32'h0BADBEEF);
    v[2] = ~v[2];
    start_cmd(6'd13, 32'hA5A5A5A5, 1'b1, 1'b0);
    tx_frame(6'd13, 32'hA5A5A5A5, 1'b1);
    rx_reply(v, 48, 2);
    chk("R6 crc fail flag", status, 4'b0100);
    chk("R6 word0 loaded", resp_o[127:96], 32'h0BADBEEF);
    chk("R6 words1-3 kept", resp_o[95:0], keep[95:0]);

    // R6 / R5 long reply with damaged payload
    v = mk_long(120'h00FF00FF00FF00FF00FF00FF00FF00);
    v[50] = ~v[50];
    start_cmd(6'd9, 32'h1, 1'b1, 1'b1);
    tx_frame(6'd9, 32'h1, 1'b1);
    rx_reply(v, 136, 1);
    chk("R6 long crc fail flag", status, 4'b0100);
    chk("R5 long words on fail", resp_o, v[127:0]);

    // R7 timeout after 64 high samples
    start_cmd(6'd55, 32'h77, 1'b1, 1'b0);
    tx_frame(6'd55, 32'h77, 1'b1);
    repeat (63) tk(1'b1);
    chk("R7 still waiting at 63", {busy, status}, 5'b10000);
    tk(1'b1);
    exp_busy = 1'b0;
    chk("R7 timeout flag", status, 4'b1000);

    // R7 start bit on the 64th sample is accepted
    start_cmd(6'd8, 32'h1AA, 1'b1, 1'b0);
    tx_frame(6'd8, 32'h1AA, 1'b1);
    rx_reply(mk_short(6'd8, 32'h13572468), 48, 63);
    chk("R7 late start accepted", status, 4'b0010);
    chk("R7 late reply word0", resp_o[127:96], 32'h13572468);

    // R8 abort during send
    keep = resp_o;
    start_cmd(6'd3, 32'hDEAD0000, 1'b1, 1'b0);
    repeat (10) tk(1'b1);
    wr(1'b1, 32'h0, 1'b0, 1'b1);
    chk("R8 abort in send", {busy, cmd_oe, cmd_out, status}, 7'b0010000);
    repeat (50) tk(1'b0);
    chk("R8 no effect after abort", {busy, status}, 5'b00000);
    chk("R8 words untouched", resp_o, keep);

    // R8 abort while waiting, enable clear but other bits set
    start_cmd(6'd5, 32'h0, 1'b1, 1'b0);
    tx_frame(6'd5, 32'h0, 1'b1);
    repeat (3) tk(1'b1);
    wr(1'b1, 32'h000000C5, 1'b0, 1'b1);
    chk("R8 abort in wait", {busy, status}, 5'b00000);
    repeat (70) tk(1'b1);
    chk("R8 no timeout after abort", status, 0);

    // R9 abort on the same cycle as the final reply bit tick
    keep = resp_o;
    v = mk_short(6'd21, 32'h55AA55AA);
    start_cmd(6'd21, 32'h4, 1'b1, 1'b0);
    tx_frame(6'd21, 32'h4, 1'b1);
    rx_reply(v, 47, 4);
    exp_busy = 1'b1;
    wr(1'b1, 32'h0, 1'b1, 1'b1);
    chk("R9 abort wins status", {busy, status}, 5'b00000);
    chk("R9 abort wins words", resp_o, keep);

    // R11 no tick, no progress
    start_cmd(6'd1, 32'hF0F0F0F0, 1'b0, 1'b0);
    repeat (5) tk(1'b1);
    keep = {126'b0, cmd_oe, cmd_out};
    repeat (20) @(negedge clk);
    #1;
    chk("R11 line held", {cmd_oe, cmd_out}, keep);
    chk("R11 busy held", busy, 1);
    wr(1'b1, 32'h0, 1'b0, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule